// File: doc/BRIEF.md
# Fixed-Period Watchdog Reset Timer

This block is a watchdog countdown timer behind a small register port. Its timeout is fixed when the design is elaborated: the requested time and the clock period are given as parameters in picoseconds, and the timeout in clock cycles is the requested time divided by the clock period, rounded up. After reset the timer sits stopped. Software arms it once by writing the START bit, and from then on nothing can halt it. To keep the system alive, software must write any value to one of the period offsets before the count runs out. Each such write reloads the fixed count. If software fails to do so, the block raises `reset_req` for one clock, which the surrounding reset network uses to restart the system.

The control state machine has three states. `WD_HALTED` is the state after reset. The transition `arm` (a START write) moves it to `WD_COUNTING`, which decrements the counter once per clock. From `WD_COUNTING`, the transition `kick` (a period write) reloads the counter and stays in `WD_COUNTING`. The transition `lapse` (count at 1 with no kick) enters `WD_EXPIRED`. That state lasts exactly one clock with the counter at zero and drives `reset_req`. The transition `rearm` then reloads and returns to `WD_COUNTING`. With a loaded value of TIMEOUT−1, one full lap takes TIMEOUT clocks, counting the zero cycle. The counter stays running, so if the external reset never arrives, another pulse follows every TIMEOUT clocks.

Top module: `wdog_reset_timer`

## Requirements
- R1: After reset the timer is stopped: `reset_req` is 0, a read of offset 0 returns 0x0000, and no pulse ever appears while stopped.
- R2: A write to offset 1 with data bit 2 set starts the timer. The first `reset_req` pulse appears TIMEOUT−1 clock edges after the edge that took the write. A write to offset 1 with bit 2 clear does not start it.
- R3: Once started, the timer keeps running whatever is written: bit 3 of offset 1 (stop request), other control data and status writes neither stop it nor shift the pulse schedule.
- R4: Each expiry holds `reset_req` high for exactly one clock cycle.
- R5: Offset 0 reads bit 1 = running and bit 0 = sticky timeout flag. The flag sets when the count expires. Any write to offset 0 clears it, except that an expiry on the same edge wins and the flag stays set.
- R6: A write of any data to offset 2 or 3 (a kick) while running reloads the count. The next pulse appears TIMEOUT−1 edges after the kick's edge, and none appears before it. This includes a kick that lands on the edge where the count would have expired.
- R7: After a pulse the counter reloads by itself and keeps running, so pulses repeat every TIMEOUT clocks while no kick arrives.
- R8: TIMEOUT = ceil(TIMEOUT_PS / CLK_PERIOD_PS). Offset 2 reads bits 15:0 and offset 3 reads bits 31:16 of TIMEOUT−1. Offset 1 and offsets 4 to 7 read 0.
- R9: Period-offset writes while stopped do not start the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register word offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, zero when `bus_rd` is low |
| reset_req | output | 1 | One-cycle system reset request on expiry |

## Verification
The assertions assume that a start request and a kick never arrive together. They also assume that a write strobe lasts one cycle per access, and that TIMEOUT is at least 2, so the counter always passes through a nonzero value before the zero cycle. The bench drives each write as a single-cycle strobe with one address at a time. It never combines a START write with a period write. It uses a 12-cycle timeout, small enough that a kick can be placed at every position of one lap, including the expiry edge itself.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;

    typedef enum logic [1:0] {
        WD_HALTED   = 2'd0,
        WD_COUNTING = 2'd1,
        WD_EXPIRED  = 2'd2
    } wd_state_e;

    // Register word offsets; the period words follow the control word.
    localparam int WD_OFF_STATUS  = 0;
    localparam int WD_OFF_CONTROL = 1;
    localparam int WD_OFF_PERIOD0 = 2;

    // Field positions inside the status and control words.
    localparam int WD_BIT_TO    = 0;
    localparam int WD_BIT_RUN   = 1;
    localparam int WD_BIT_START = 2;

    // Rounds a time up to a whole number of clock cycles.
    function automatic int unsigned wd_ceil_cycles(input longint unsigned t_ps,
                                                   input longint unsigned clk_ps);
        longint unsigned q;
        q = (t_ps + clk_ps - 64'd1) / clk_ps;
        return int'(q);
    endfunction

endpackage

// File: rtl/wdt_bus_decode.sv
`timescale 1ns/1ps
module wdt_bus_decode
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16,
    parameter int WORDS  = 2
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              start_req,
    output logic              kick_req,
    output logic              status_wr
);

    logic [WORDS-1:0] hit_period;
    logic             unused_wdata;

    generate
        for (genvar gi = 0; gi < WORDS; gi++) begin : g_period_hit
            assign hit_period[gi] = (bus_addr == ADDR_W'(WD_OFF_PERIOD0 + gi));
        end
    endgenerate

    always_comb begin
        start_req = bus_wr && (bus_addr == ADDR_W'(WD_OFF_CONTROL))
                    && bus_wdata[WD_BIT_START];
        kick_req  = bus_wr && (|hit_period);
        status_wr = bus_wr && (bus_addr == ADDR_W'(WD_OFF_STATUS));
    end

    // Stop request and all other data bits carry no meaning here.
    assign unused_wdata = ^{bus_wdata[DATA_W-1:WD_BIT_START+1],
                            bus_wdata[WD_BIT_START-1:0]};

endmodule

// File: rtl/wdt_countdown.sv
`timescale 1ns/1ps
module wdt_countdown #(
    parameter int              CNT_W    = 32,
    parameter logic [CNT_W-1:0] LOAD_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             at_one
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= LOAD_VAL;
        end else if (load) begin
            count <= LOAD_VAL;
        end else if (dec) begin
            count <= count - CNT_W'(1);
        end
    end

    assign at_one = (count == CNT_W'(1));

endmodule

// File: rtl/wdt_ctrl_fsm.sv
`timescale 1ns/1ps
module wdt_ctrl_fsm
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic kick_req,
    input  logic status_wr,
    input  logic at_one,
    output logic load,
    output logic dec,
    output logic run,
    output logic to_flag,
    output logic reset_req
);

    wd_state_e state, state_nx;
    logic      lapse;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WD_HALTED;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions: arm, kick, lapse, rearm
    always_comb begin
        state_nx = state;
        lapse    = 1'b0;
        unique case (state)
            WD_HALTED: begin
                if (start_req) state_nx = WD_COUNTING;   // arm
            end
            WD_COUNTING: begin
                if (kick_req) begin
                    state_nx = WD_COUNTING;              // kick
                end else if (at_one) begin
                    state_nx = WD_EXPIRED;               // lapse
                    lapse    = 1'b1;
                end
            end
            WD_EXPIRED: begin
                state_nx = WD_COUNTING;                  // rearm
            end
            default: state_nx = WD_HALTED;
        endcase
    end

    // Outputs and counter commands
    always_comb begin
        load      = 1'b0;
        dec       = 1'b0;
        run       = 1'b0;
        reset_req = 1'b0;
        unique case (state)
            WD_HALTED: begin
                load = kick_req;
            end
            WD_COUNTING: begin
                run  = 1'b1;
                load = kick_req;
                dec  = !kick_req;
            end
            WD_EXPIRED: begin
                run       = 1'b1;
                load      = 1'b1;
                reset_req = 1'b1;
            end
            default: ;
        endcase
    end

    // Sticky timeout flag; an expiry on the same edge beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_flag <= 1'b0;
        end else if (lapse) begin
            to_flag <= 1'b1;
        end else if (status_wr) begin
            to_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/wdt_readback.sv
`timescale 1ns/1ps
module wdt_readback
    import wdt_pkg::*;
#(
    parameter int               ADDR_W   = 3,
    parameter int               DATA_W   = 16,
    parameter int               CNT_W    = 32,
    parameter int               WORDS    = 2,
    parameter logic [CNT_W-1:0] LOAD_VAL = '1
) (
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              run,
    input  logic              to_flag,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int PAD_W = WORDS * DATA_W;
    localparam logic [PAD_W-1:0] LOAD_PAD = PAD_W'(LOAD_VAL);

    logic [DATA_W-1:0] period_word [WORDS];
    logic [DATA_W-1:0] status_word;

    generate
        for (genvar gi = 0; gi < WORDS; gi++) begin : g_period_word
            assign period_word[gi] = LOAD_PAD[gi*DATA_W +: DATA_W];
        end
    endgenerate

    always_comb begin
        status_word = '0;
        status_word[WD_BIT_TO]  = to_flag;
        status_word[WD_BIT_RUN] = run;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == ADDR_W'(WD_OFF_STATUS)) begin
                bus_rdata = status_word;
            end
            for (int i = 0; i < WORDS; i++) begin
                if (bus_addr == ADDR_W'(WD_OFF_PERIOD0 + i)) begin
                    bus_rdata = period_word[i];
                end
            end
        end
    end

endmodule

// File: rtl/wdog_reset_timer.sv
`timescale 1ns/1ps
module wdog_reset_timer
    import wdt_pkg::*;
#(
    parameter int unsigned TIMEOUT_PS    = 1_000_000,
    parameter int unsigned CLK_PERIOD_PS = 5_000,
    parameter int          CNT_W         = 32,
    parameter int          DATA_W        = 16,
    parameter int          ADDR_W        = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              reset_req
);

    localparam int unsigned TIMEOUT_CYC = wd_ceil_cycles(64'(TIMEOUT_PS), 64'(CLK_PERIOD_PS));
    localparam int unsigned LOAD_INT    = TIMEOUT_CYC - 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(LOAD_INT);
    localparam int WORDS = (CNT_W + DATA_W - 1) / DATA_W;

    generate
        if (TIMEOUT_CYC < 2) begin : g_bad_timeout
            $error("timeout must span at least two clock cycles");
        end
        if (WD_OFF_PERIOD0 + WORDS > (1 << ADDR_W)) begin : g_bad_addr
            $error("address width too small for the period words");
        end
    endgenerate

    logic             start_req;
    logic             kick_req;
    logic             status_wr;
    logic             load;
    logic             dec;
    logic             at_one;
    logic             run;
    logic             to_flag;
    logic [CNT_W-1:0] count;

    wdt_bus_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .WORDS  (WORDS)
    ) u_decode (
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .start_req (start_req),
        .kick_req  (kick_req),
        .status_wr (status_wr)
    );

    wdt_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .kick_req  (kick_req),
        .status_wr (status_wr),
        .at_one    (at_one),
        .load      (load),
        .dec       (dec),
        .run       (run),
        .to_flag   (to_flag),
        .reset_req (reset_req)
    );

    wdt_countdown #(
        .CNT_W    (CNT_W),
        .LOAD_VAL (LOAD_VAL)
    ) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .dec    (dec),
        .count  (count),
        .at_one (at_one)
    );

    wdt_readback #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CNT_W    (CNT_W),
        .WORDS    (WORDS),
        .LOAD_VAL (LOAD_VAL)
    ) u_readback (
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .run       (run),
        .to_flag   (to_flag),
        .bus_rdata (bus_rdata)
    );

endmodule

// File: rtl/wdt_checker.sv
`timescale 1ns/1ps
module wdt_checker #(
    parameter int               CNT_W    = 32,
    parameter logic [CNT_W-1:0] LOAD_VAL = '1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_req,
    input logic             kick_req,
    input logic             status_wr,
    input logic             reset_req,
    input logic             run,
    input logic             to_flag,
    input logic [CNT_W-1:0] count
);

    p_halt_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !reset_req);

    p_arm_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> $past(start_req));

    p_never_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> run);

    p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    p_flag_on_expiry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> to_flag);

    p_flag_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        status_wr |=> (to_flag == reset_req));

    p_kick_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_req && run) |=> (!reset_req && count == LOAD_VAL));

    p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && count > CNT_W'(1) && !kick_req) |=> (count == $past(count) - CNT_W'(1)));

    p_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> (run && count == LOAD_VAL));

    p_kick_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && kick_req && !start_req) |=> !run);

endmodule

bind wdog_reset_timer wdt_checker #(
    .CNT_W    (CNT_W),
    .LOAD_VAL (LOAD_VAL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .kick_req  (kick_req),
    .status_wr (status_wr),
    .reset_req (reset_req),
    .run       (run),
    .to_flag   (to_flag),
    .count     (count)
);

// File: tb/wdog_reset_timer_tb_top.sv
`timescale 1ns/1ps
module wdog_reset_timer_tb_top;

    localparam int unsigned T_PS   = 57_001;
    localparam int unsigned CLK_PS = 5_000;
    localparam int TOUT = int'((T_PS + CLK_PS - 1) / CLK_PS);   // 12
    localparam int LD   = TOUT - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        reset_req;

    int cyc = 0;
    int pulse_cnt = 0;
    int last_pulse = -1;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && reset_req) begin
            pulse_cnt  = pulse_cnt + 1;
            last_pulse = cyc;
        end
    end

    wdog_reset_timer #(
        .TIMEOUT_PS    (T_PS),
        .CLK_PERIOD_PS (CLK_PS)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .reset_req (reset_req)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    // Returns the edge index that captures the write.
    task automatic wr(input int a, input int d, output int edge_idx);
        bus_addr  = 3'(a);
        bus_wdata = 16'(d);
        bus_wr    = 1'b1;
        edge_idx  = cyc + 1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        bus_addr = 3'(a);
        bus_rd   = 1'b1;
        #1;
        v = int'(bus_rdata);
        bus_rd = 1'b0;
    endtask

    task automatic wait_pulse(input string req, output int at, output int got);
        int c0;
        c0  = pulse_cnt;
        got = 0;
        for (int i = 0; i < 3 * TOUT && pulse_cnt == c0; i++) tick();
        got = pulse_cnt - c0;
        at  = last_pulse;
        if (got == 0) chk(1'b0, req, "pulse missing", 0, 1);
    endtask

    task automatic run_all();
        int v, s, p, e, got, dmy;

        repeat (4) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk(reset_req == 1'b0, "R1", "reset_req after reset", int'(reset_req), 0);
        rd(0, v);
        chk(v == 0, "R1", "status after reset", v, 0);

        // R8 readback of every offset
        for (int a = 0; a < 8; a++) begin
            int exp;
            exp = (a == 2) ? (LD & 16'hFFFF) : (a == 3) ? ((LD >> 16) & 16'hFFFF) : 0;
            rd(a, v);
            chk(v == exp, "R8", $sformatf("read offset %0d", a), v, exp);
        end

        // R9 / R2 writes that must not start the timer
        wr(2, 16'hFFFF, dmy);
        wr(3, 16'h0000, dmy);
        wr(1, 16'h000B, dmy);
        repeat (3 * TOUT) tick();
        chk(pulse_cnt == 0, "R1", "pulses while stopped", pulse_cnt, 0);
        rd(0, v);
        chk(v == 0, "R9", "status after period writes / non-start control", v, 0);

        // R2 start
        wr(1, 16'h0004, s);
        rd(0, v);
        chk(v == 2, "R2", "status running", v, 2);
        wait_pulse("R2", p, got);
        chk(p == s + LD, "R2", "first pulse cycle", p, s + LD);
        tick();
        chk(reset_req == 1'b0, "R4", "pulse width", int'(reset_req), 0);
        chk(pulse_cnt == 1, "R4", "pulse count after first expiry", pulse_cnt, 1);
        rd(0, v);
        chk(v == 3, "R5", "timeout flag set", v, 3);
        wr(0, 16'h0000, dmy);
        rd(0, v);
        chk(v == 2, "R5", "timeout flag cleared, run kept", v, 2);

        // R3 stop attempts
        wr(1, 16'h0008, dmy);
        wr(1, 16'h0000, dmy);
        wr(0, 16'hFFFF, dmy);
        rd(0, v);
        chk(v == 2, "R3", "still running after stop write", v, 2);

        // R5 set beats clear on the expiry edge; R7 repeat period
        while (cyc < p + TOUT - 1) tick();
        wr(0, 16'h0000, e);
        chk(e == p + TOUT, "R5", "clear aligned to expiry edge", e, p + TOUT);
        rd(0, v);
        chk(v == 3, "R5", "flag set wins over clear", v, 3);
        chk(last_pulse == p + TOUT, "R7", "repeat pulse cycle", last_pulse, p + TOUT);
        p = p + TOUT;

        // R6 kick at every position of one lap, expiry edge included
        for (int k = 1; k <= LD + 1; k++) begin
            int exp_at;
            e = p + k;
            while (cyc < e - 1) tick();
            wr(2 + (k % 2), k * 16'h1357, e);
            exp_at = e + LD;
            wait_pulse("R6", p, got);
            chk(p == exp_at, "R6", $sformatf("pulse after kick offset %0d", k), p, exp_at);
            chk(got == 1, "R6", $sformatf("pulse count after kick offset %0d", k), got, 1);
        end

        // R7 free-running repeat after the sweep
        s = p;
        wait_pulse("R7", p, got);
        chk(p == s + TOUT, "R7", "repeat after sweep", p, s + TOUT);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100_000) @(posedge clk);
                chk(1'b0, "R1", "watchdog expired", 0, 1);
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule